// File: doc/BRIEF.md
# Presettable Decimal Up/Down Digit Counter

This block holds one decimal digit as a 4-bit BCD value and steps it once per rising clock edge. It can count up or count down, hold its value, or take a preset value. The preset path is an active-low load that copies a 4-bit data input into the digit. The counting path is gated by an active-low enable and steered by a single direction input. An active-low synchronous reset clears the digit to zero.

Two status outputs support cascading several digits. The end-of-range flag is high when the digit sits at the last value for the current direction. That value is nine when counting up and zero when counting down. The flag follows the direction input at once, and the enable has no effect on it. The carry/borrow strobe is active low and is derived from the clock. It reproduces the low phase of the clock only when the flag is high and counting is enabled, so it can drive the next digit's clock or enable.

Codes ten to fifteen can only arrive through the preset path. The counter leaves them on its next count step.

Top module: `bcd_updown_digit`

## Requirements
- R1: With `rst_n` low at a rising edge, the digit becomes 0 after that edge. Reset takes priority over load and count.
- R2: With `rst_n` and `load_n` high, the digit changes at a rising edge only if `cnt_en_n` was low. With `cnt_en_n` high, the digit keeps its value.
- R3: With `dir_down` = 0 (up), an enabled edge adds one to the digit. The step from 9 goes to 0.
- R4: With `dir_down` = 1 (down), an enabled edge subtracts one from the digit. The step from 0 goes to 9.
- R5: With `rst_n` high and `load_n` low at a rising edge, the digit takes the value of `data_in`. This happens whatever the values of `cnt_en_n` and `dir_down`.
- R6: `term_cnt` is high exactly when the digit is 9 with `dir_down` = 0, or 0 with `dir_down` = 1. It follows `dir_down` without waiting for a clock edge, and `cnt_en_n` has no effect on it.
- R7: `ripple_n` is low only while `term_cnt` is high, `cnt_en_n` is low and `clk` is low. At all other times it is high.
- R8: From a code of 10 to 15, an enabled up step goes to 0. An enabled down step goes to the code minus one, or to 9 if that result is still above 9. With these codes loaded, the digit never stays illegal after an enabled step, and `term_cnt` stays low while the code is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous clear to 0 |
| load_n | input | 1 | Active-low synchronous preset from `data_in` |
| data_in | input | 4 | Preset value |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| digit_q | output | 4 | Current digit value |
| term_cnt | output | 1 | End-of-range flag for the current direction |
| ripple_n | output | 1 | Active-low, clock-gated carry/borrow strobe |

## Verification
The bench builds the block with its defaults, a 4-bit state and a radix of ten. With these values the codes 10 to 15 can be reached through the load path, so the route back from an illegal code is exercised in both directions. The bench also samples both clock phases. In the low phase it checks the strobe and the flag, including a change of direction at 0 and at 9 while the enable is high. In the high phase it checks that the strobe has returned high.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } digit_op_e;

    // Load outranks counting; counting needs the enable low.
    function automatic digit_op_e pick_op(input logic load_n,
                                          input logic cnt_en_n,
                                          input logic dir_down);
        digit_op_e op;
        if (!load_n)        op = OP_LOAD;
        else if (cnt_en_n)  op = OP_HOLD;
        else if (dir_down)  op = OP_DOWN;
        else                op = OP_UP;
        return op;
    endfunction

endpackage

// File: rtl/bcd_step_calc.sv
module bcd_step_calc
    import bcd_digit_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned RADIX = 10
) (
    input  digit_op_e          op,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   load_val,
    output logic [WIDTH-1:0]   nxt
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(RADIX - 1);

    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] dec_v;

    generate
        if (RADIX == (1 << WIDTH)) begin : g_full_range
            // Every code is legal; the natural wrap is the decimal wrap.
            assign inc_v = cur + 1'b1;
            assign dec_v = cur - 1'b1;
        end else begin : g_part_range
            logic             legal;
            logic [WIDTH-1:0] dec_raw;
            assign legal   = (cur <= TOP_V);
            assign dec_raw = cur - 1'b1;
            always_comb begin
                if (legal && (cur != TOP_V)) inc_v = cur + 1'b1;
                else                         inc_v = '0;
            end
            always_comb begin
                if (cur == '0)            dec_v = TOP_V;
                else if (dec_raw > TOP_V) dec_v = TOP_V;
                else                      dec_v = dec_raw;
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = load_val;
            OP_UP:   nxt = inc_v;
            OP_DOWN: nxt = dec_v;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned RADIX = 10
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_down,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(RADIX - 1);

    logic at_top;
    logic at_zero;

    assign at_top  = (cur == TOP_V);
    assign at_zero = (cur == '0);
    assign tc      = dir_down ? at_zero : at_top;

endmodule

// File: rtl/bcd_ripple_gate.sv
module bcd_ripple_gate (
    input  logic clk,
    input  logic tc,
    input  logic cnt_en_n,
    output logic ripple_n
);
    // Passes the clock low phase only at the carry/borrow point.
    assign ripple_n = ~(tc & ~cnt_en_n & ~clk);

endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
    import bcd_digit_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned RADIX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    output logic [WIDTH-1:0] digit_q,
    output logic             term_cnt,
    output logic             ripple_n
);
    typedef struct packed {
        logic [WIDTH-1:0] digit;
    } digit_state_t;

    digit_state_t     state_d;
    digit_state_t     state_q;
    digit_op_e        op_sel;
    logic [WIDTH-1:0] step_nxt;
    logic             tc_w;

    assign op_sel = pick_op(load_n, cnt_en_n, dir_down);

    bcd_step_calc #(.WIDTH(WIDTH), .RADIX(RADIX)) u_step (
        .op       (op_sel),
        .cur      (state_q.digit),
        .load_val (data_in),
        .nxt      (step_nxt)
    );

    bcd_tc_decode #(.WIDTH(WIDTH), .RADIX(RADIX)) u_tc (
        .cur      (state_q.digit),
        .dir_down (dir_down),
        .tc       (tc_w)
    );

    bcd_ripple_gate u_ripple (
        .clk      (clk),
        .tc       (tc_w),
        .cnt_en_n (cnt_en_n),
        .ripple_n (ripple_n)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) state_d.digit = '0;
        else        state_d.digit = step_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign digit_q  = state_q.digit;
    assign term_cnt = tc_w;

endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned RADIX = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] data_in,
    input logic             cnt_en_n,
    input logic             dir_down,
    input logic [WIDTH-1:0] digit_q,
    input logic             term_cnt,
    input logic             ripple_n
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(RADIX - 1);

    p_clear_r1: assert property (@(posedge clk)
        !rst_n |=> digit_q == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> $stable(digit_q));

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !dir_down && digit_q == TOP_V) |=> digit_q == '0);

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && dir_down && digit_q == '0) |=> digit_q == TOP_V);

    p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> digit_q == $past(data_in));

    p_flag_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> (digit_q == '0 || digit_q == TOP_V));

    // Sampled values at the rising edge belong to the clock low phase.
    p_strobe_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ripple_n |-> (term_cnt && !cnt_en_n));

    p_strobe_high_r7: assert property (@(negedge clk) disable iff (!rst_n)
        ripple_n);

    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && digit_q > TOP_V) |=> digit_q <= TOP_V);

endmodule

bind bcd_updown_digit bcd_updown_digit_chk #(.WIDTH(WIDTH), .RADIX(RADIX)) u_chk (.*);

// File: tb/bcd_updown_digit_bench.sv
`timescale 1ns/1ps
module bcd_updown_digit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data_in = 4'd0;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic [3:0] digit_q;
    logic       term_cnt;
    logic       ripple_n;

    int checks = 0;
    int failures = 0;
    int model = 0;

    always #2 clk = ~clk;

    bcd_updown_digit u_bcd_updown_digit (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .data_in(data_in),
        .cnt_en_n(cnt_en_n), .dir_down(dir_down), .digit_q(digit_q),
        .term_cnt(term_cnt), .ripple_n(ripple_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int flag_of(input int m, input logic dn);
        if (dn) return (m == 0) ? 1 : 0;
        return (m == 9) ? 1 : 0;
    endfunction

    // One clock: drive in low phase, check flag/strobe, edge, check result.
    task automatic step(input logic rs, input logic ld, input int d,
                        input logic en_n, input logic dn, input string req);
        int fl;
        @(negedge clk);
        rst_n = rs; load_n = ld; data_in = 4'(d); cnt_en_n = en_n; dir_down = dn;
        #1;
        fl = flag_of(model, dn);
        chk("R6 flag low phase", int'(term_cnt), fl);
        chk("R7 strobe low phase", int'(ripple_n), (fl == 1 && !en_n) ? 0 : 1);
        @(posedge clk);
        if (!rs)          model = 0;
        else if (!ld)     model = d;
        else if (!en_n) begin
            if (!dn) model = (model > 9) ? 0 : (model + 1) % 10;
            else     model = (model > 9) ? ((model - 1 > 9) ? 9 : model - 1)
                                         : (model + 9) % 10;
        end
        #1;
        chk(req, int'(digit_q), model);
        chk("R6 flag after edge", int'(term_cnt), flag_of(model, dn));
        chk("R7 strobe high phase", int'(ripple_n), 1);
    endtask

    initial begin
        step(0, 1, 0, 1, 0, "R1 reset clears");
        step(0, 0, 5, 0, 0, "R1 reset over load");
        step(1, 0, 7, 1, 0, "R5 load 7");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R3 count up 8,9,0,1,2");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, "R2 inhibit holds");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 1, "R4 count down 1,0,9,8,7");
        step(1, 0, 9, 1, 0, "R5 load 9");
        step(1, 1, 0, 1, 1, "R6 direction flip at 9 drops flag");
        step(1, 1, 0, 1, 0, "R6 flag high with enable off");
        step(1, 1, 0, 0, 0, "R3 wrap 9 to 0");
        step(1, 1, 0, 1, 1, "R6 flag at 0 counting down");
        step(1, 1, 0, 0, 1, "R4 wrap 0 to 9");
        step(1, 0, 3, 0, 1, "R5 load overrides count");
        step(1, 0, 12, 1, 0, "R5 load illegal 12");
        step(1, 1, 0, 1, 1, "R8 flag low on illegal code");
        step(1, 1, 0, 0, 0, "R8 illegal up goes to 0");
        step(1, 0, 15, 1, 0, "R5 load illegal 15");
        step(1, 1, 0, 0, 1, "R8 illegal 15 down goes to 9");
        step(1, 0, 10, 1, 0, "R5 load illegal 10");
        step(1, 1, 0, 0, 1, "R8 illegal 10 down goes to 9");
        step(1, 0, 11, 1, 0, "R5 load illegal 11");
        step(1, 1, 0, 0, 1, "R8 illegal 11 down goes to 9");
        step(0, 1, 0, 0, 0, "R1 reset mid-run");
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step((r < 3) ? 1'b0 : 1'b1, (r > 85) ? 1'b0 : 1'b1,
                 int'($urandom_range(0, 15)), (r % 4 == 0) ? 1'b1 : 1'b0,
                 1'($urandom_range(0, 1)), "R2 R3 R4 mixed stepping");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule